// File: doc/BRIEF.md
# DMA Request Routing Multiplexer

This block sits between a set of peripheral DMA request lines and the request inputs of a 16-channel DMA engine. Each output channel has one configuration byte. That byte picks which source request feeds the channel and whether the channel is off, passes the request straight through, or lets the request through only after a pulse from an external interval timer. Software sets up the channels through a small byte-addressed write and read port. Channel n sits at byte offset n.

In the timer-gated mode, a one-cycle trigger pulse arms the channel. The next time the selected source is requesting, the channel passes that request for exactly one cycle and then disarms. A peripheral whose buffer stays ready therefore gets serviced once per timer period. Only the four lowest channels have a trigger input. The upper twelve channels can only be off or transparent.

Top module: `dma_req_router`

## Requirements
- R1: Configuration byte n is written at offset n (0x00 to 0x0F) and reads back on `rdata` in the same cycle that `addr` selects it. The byte layout is: bit 7 enable, bit 6 trigger gating, bits 5:0 source number.
- R2: After reset, every configuration byte reads 0x00 and every `ch_req` bit is 0.
- R3: A channel whose enable bit is 0 holds its `ch_req` bit at 0, whatever its source request does.
- R4: When a channel has enable=1 and trigger gating=0, its `ch_req` bit equals `src_req[source]` combinationally, in the same cycle.
- R5: Source number 0 selects nothing, and the channel output stays 0 even when all source requests are high.
- R6: On channels 4 to 15, bit 6 always reads 0 and writes to it are dropped. Such a channel with enable=1 behaves as in R4.
- R7: On channels 0 to 3 with enable=1 and trigger gating=1, the output stays 0 until a pulse on `trig_in[n]`. From the cycle after the pulse, the output equals the selected source request while the channel is armed.
- R8: An armed channel disarms on the clock edge that ends a cycle in which its output was 1. The output is then 0 until the next trigger pulse. If the source is low, the armed state is kept.
- R9: A cycle with enable=0 discards any armed state. Re-enabling therefore gives no output until a new trigger pulse arrives.
- R10: Trigger gating set with enable=0 leaves the channel disabled. A trigger pulse then neither drives the output nor arms the channel.
- R11: Reads of offsets 0x10 and above return 0x00, and writes to them change no channel.
- R12: A write takes effect at the clock edge that ends its cycle. During the write cycle the output still follows the old configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the configuration port |
| addr | input | 8 | Byte offset for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| src_req | input | 64 | Peripheral request lines, index = source number |
| trig_in | input | 4 | One-cycle trigger pulses for channels 0 to 3 |
| ch_req | output | 16 | Request lines to the DMA engine channels |

## Verification
Transparent routing is tried with the source toggling under a fixed configuration, with all sources high behind a disabled channel, and behind source number 0. This separates gating by enable from gating by source select. Timer gating is tried in three ways: a pulse arriving while the source is already high, a pulse arriving while the source is low with the source rising later, and a pulse followed by a disable and re-enable. Together these separate the one-shot consumption of the armed state from holding that state and from discarding it. Writes to an upper channel's trigger bit, to offsets past the map, and with trigger gating on a disabled channel show which configuration bits the router actually honours. A mid-write observation pins down the cycle in which a new configuration takes effect.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  localparam int SEL_W    = 6;
  localparam int CFG_W    = 8;
  localparam int EN_BIT   = CFG_W - 1;
  localparam int TRIG_BIT = CFG_W - 2;

  typedef struct packed {
    logic             en;
    logic             trig_en;
    logic [SEL_W-1:0] sel;
  } ch_cfg_t;

endpackage

// File: rtl/dmr_cfg_regs.sv
module dmr_cfg_regs
  import dmr_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG_CH = 4,
  parameter int ADDR_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CFG_W-1:0]       wdata,
  output logic [CFG_W-1:0]       rdata,
  output ch_cfg_t [NUM_CH-1:0]   cfg_o
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic in_range;
  assign in_range = (addr < ADDR_W'(NUM_CH));

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic             hit;
    logic             en_q;
    logic             en_d;
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_d;

    assign hit = wr_en && (addr == ADDR_W'(gi));

    always_comb begin
      en_d  = wdata[EN_BIT];
      sel_d = wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        sel_q <= '0;
      end else if (hit) begin
        en_q  <= en_d;
        sel_q <= sel_d;
      end
    end

    assign cfg_o[gi].en  = en_q;
    assign cfg_o[gi].sel = sel_q;

    if (gi < NUM_TRIG_CH) begin : g_trig
      logic trig_q;
      logic trig_d;
      always_comb trig_d = wdata[TRIG_BIT];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   trig_q <= 1'b0;
        else if (hit) trig_q <= trig_d;
      end
      assign cfg_o[gi].trig_en = trig_q;
    end else begin : g_notrig
      assign cfg_o[gi].trig_en = 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_range) rdata = cfg_o[addr[IDX_W-1:0]];
  end

  // R11: a write outside the map leaves every channel byte as it was
  a_r11_unmapped_write_ignored: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> $stable(cfg_o));

  // R11: reads outside the map return zero
  a_r11_unmapped_read_zero: assert property (
    @(posedge clk) disable iff (!rst_n)
    !in_range |-> (rdata == '0));

endmodule

// File: rtl/dmr_src_select.sv
module dmr_src_select #(
  parameter int NUM_CH  = 16,
  parameter int NUM_SRC = 64,
  parameter int SEL_W   = 6
) (
  input  logic [NUM_SRC-1:0]           src_req,
  input  logic [NUM_CH-1:0][SEL_W-1:0] sel_i,
  output logic [NUM_CH-1:0]            req_o
);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_mux
    always_comb begin
      req_o[gi] = 1'b0;
      if ((sel_i[gi] != '0) && (int'(sel_i[gi]) < NUM_SRC))
        req_o[gi] = src_req[sel_i[gi]];
    end
  end

endmodule

// File: rtl/dmr_trig_gate.sv
module dmr_trig_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trig_en,
  input  logic trig_pulse,
  input  logic req_in,
  output logic req_out
);

  logic periodic;
  logic grant;
  logic pend_q;
  logic pend_d;
  logic pend_ce;

  assign periodic = en & trig_en;
  assign grant    = periodic & pend_q & req_in;
  assign pend_ce  = periodic | pend_q;

  always_comb begin
    pend_d = 1'b0;
    if (periodic) pend_d = trig_pulse | (pend_q & ~grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end

  always_comb begin
    req_out = 1'b0;
    if (en) req_out = trig_en ? grant : req_in;
  end

  // R7: a pulse in gated mode arms the channel
  a_r7_pulse_arms: assert property (
    @(posedge clk) disable iff (!rst_n)
    (en && trig_en && trig_pulse) |=> pend_q);

  // R7: gated channel that is not armed stays quiet
  a_r7_unarmed_quiet: assert property (
    @(posedge clk) disable iff (!rst_n)
    (trig_en && !pend_q) |-> !req_out);

  // R8: a delivered request consumes the armed state
  a_r8_grant_consumes: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_out && trig_en && !trig_pulse) |=> !pend_q);

  // R8: armed state holds while the source is idle
  a_r8_hold_while_idle: assert property (
    @(posedge clk) disable iff (!rst_n)
    (pend_q && en && trig_en && !req_in) |=> pend_q);

  // R9, R10: a disabled cycle leaves nothing armed
  a_r9_disable_drops: assert property (
    @(posedge clk) disable iff (!rst_n)
    !en |=> !pend_q);

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmr_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG_CH = 4,
  parameter int NUM_SRC     = 64,
  parameter int ADDR_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [NUM_SRC-1:0]     src_req,
  input  logic [NUM_TRIG_CH-1:0] trig_in,
  output logic [NUM_CH-1:0]      ch_req
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ch_cfg_t [NUM_CH-1:0]            cfg;
  logic    [NUM_CH-1:0][SEL_W-1:0] sel_vec;
  logic    [NUM_CH-1:0]            sel_req;

  dmr_cfg_regs #(
    .NUM_CH      (NUM_CH),
    .NUM_TRIG_CH (NUM_TRIG_CH),
    .ADDR_W      (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .cfg_o (cfg)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_sel
    assign sel_vec[gi] = cfg[gi].sel;
  end

  dmr_src_select #(
    .NUM_CH  (NUM_CH),
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W)
  ) u_sel (
    .src_req (src_req),
    .sel_i   (sel_vec),
    .req_o   (sel_req)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_out
    if (gi < NUM_TRIG_CH) begin : g_gated
      dmr_trig_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .en         (cfg[gi].en),
        .trig_en    (cfg[gi].trig_en),
        .trig_pulse (trig_in[gi]),
        .req_in     (sel_req[gi]),
        .req_out    (ch_req[gi])
      );
    end else begin : g_plain
      assign ch_req[gi] = cfg[gi].en & sel_req[gi];
    end

    // R3: disabled channel never requests
    a_r3_disabled_silent: assert property (
      @(posedge clk) disable iff (!rst_int_n)
      !cfg[gi].en |-> !ch_req[gi]);

    // R5: source zero never requests
    a_r5_null_source: assert property (
      @(posedge clk) disable iff (!rst_int_n)
      (cfg[gi].sel == '0) |-> !ch_req[gi]);

    // R4: transparent routing follows the chosen line
    a_r4_transparent: assert property (
      @(posedge clk) disable iff (!rst_int_n)
      (cfg[gi].en && !cfg[gi].trig_en && cfg[gi].sel != '0)
        |-> (ch_req[gi] == src_req[cfg[gi].sel]));
  end

endmodule

// File: tb/dma_req_router_test.sv
`timescale 1ns/1ps
module dma_req_router_test;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [63:0] src;
  logic [3:0]  trg;
  logic [15:0] ch;

  dma_req_router uut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .src_req (src), .trig_in (trg),
    .ch_req (ch)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [15:0] mask;
    logic [15:0] exp;
    bit          rd_chk;
    logic [7:0]  rd_exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // monitor: compares the expected item against the outputs mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if ((ch & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: ch_req=%h expected=%h (mask %h)",
                 it.tag, ch & it.mask, it.exp & it.mask, it.mask);
      end
      if (it.rd_chk) begin
        n_chk++;
        if (rdata !== it.rd_exp) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.rd_exp);
        end
      end
    end
  end

  function automatic logic [15:0] bm(int n);
    return 16'(1) << n;
  endfunction

  // driver: queues one expectation for the current cycle, then advances
  task automatic expect_cyc(logic [15:0] mask, logic [15:0] exp, bit rd_chk,
                            logic [7:0] rd_a, logic [7:0] rd_exp, string tag);
    item_t it;
    addr = rd_a;
    it.mask = mask; it.exp = exp; it.rd_chk = rd_chk;
    it.rd_exp = rd_exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #0.5;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; src = '0; trg = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) begin @(posedge clk); #1; end

    // R2: reset state
    src = '1;
    expect_cyc(16'hFFFF, 16'h0000, 1, 8'h00, 8'h00, "R2 reset ch0 byte");
    expect_cyc(16'hFFFF, 16'h0000, 1, 8'h0F, 8'h00, "R2 reset ch15 byte");
    src = '0;

    // R1, R4: transparent routing of source 5 on channel 0
    wr(8'h00, 8'h85);
    src[5] = 1'b1;
    expect_cyc(bm(0), bm(0), 1, 8'h00, 8'h85, "R1 R4 ch0 follows high source");
    src[5] = 1'b0;
    expect_cyc(bm(0), 16'h0, 0, 8'h00, 8'h00, "R4 ch0 follows low source");

    // R12: new config applies only after the write edge
    wr(8'h00, 8'h80);
    src = '1;
    expect_cyc(bm(0), 16'h0, 1, 8'h00, 8'h80, "R5 source zero all high");
    src = '0; src[5] = 1'b1;
    wr_en = 1'b1; wdata = 8'h85;
    expect_cyc(bm(0), 16'h0, 0, 8'h00, 8'h00, "R12 old config during write");
    wr_en = 1'b0;
    expect_cyc(bm(0), bm(0), 0, 8'h00, 8'h00, "R12 new config after write");

    // R3: disabled channel with a valid source
    wr(8'h01, 8'h05);
    src = '1;
    expect_cyc(bm(1), 16'h0, 1, 8'h01, 8'h05, "R3 disabled ch1 stays low");
    src = '0;

    // R6: upper channel drops trigger bit, routes transparently
    wr(8'h09, 8'hC7);
    src[7] = 1'b1;
    expect_cyc(bm(9), bm(9), 1, 8'h09, 8'h87, "R6 ch9 trig bit dropped");
    src[7] = 1'b0;
    expect_cyc(bm(9), 16'h0, 0, 8'h00, 8'h00, "R6 ch9 follows low source");

    // R11: unmapped offsets
    wr(8'h10, 8'hFF);
    wr(8'h3F, 8'hFF);
    src[5] = 1'b1; src[7] = 1'b1;
    expect_cyc(16'hFFFF, bm(0) | bm(9), 1, 8'h10, 8'h00, "R11 offset 0x10 reads zero");
    expect_cyc(16'hFFFF, bm(0) | bm(9), 1, 8'h00, 8'h85, "R11 ch0 untouched");
    expect_cyc(16'hFFFF, bm(0) | bm(9), 1, 8'h0F, 8'h00, "R11 ch15 untouched");
    src = '0;

    // R7, R8: trigger with source already high on channel 2
    wr(8'h02, 8'hC3);
    src[3] = 1'b1;
    expect_cyc(bm(2), 16'h0, 1, 8'h02, 8'hC3, "R7 ch2 quiet before trigger");
    trg[2] = 1'b1;
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R7 ch2 quiet in pulse cycle");
    trg[2] = 1'b0;
    expect_cyc(bm(2), bm(2), 0, 8'h00, 8'h00, "R7 ch2 requests after pulse");
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R8 ch2 one shot consumed");
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R8 ch2 stays quiet");

    // R8: armed state held while source is low
    src[3] = 1'b0;
    trg[2] = 1'b1;
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R8 pulse with idle source");
    trg[2] = 1'b0;
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R8 armed idle source");
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R8 armed idle source later");
    src[3] = 1'b1;
    expect_cyc(bm(2), bm(2), 0, 8'h00, 8'h00, "R8 held arm delivers");
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R8 held arm consumed");

    // R9: disable discards the armed state
    src[3] = 1'b0;
    trg[2] = 1'b1;
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R9 arm before disable");
    trg[2] = 1'b0;
    wr(8'h02, 8'h43);
    wr(8'h02, 8'hC3);
    src[3] = 1'b1;
    expect_cyc(bm(2), 16'h0, 0, 8'h00, 8'h00, "R9 re-enable without trigger");
    expect_cyc(bm(2), 16'h0, 1, 8'h02, 8'hC3, "R9 still quiet");

    // R10: trigger gating with enable clear
    wr(8'h03, 8'h44);
    src[4] = 1'b1;
    trg[3] = 1'b1;
    expect_cyc(bm(3), 16'h0, 1, 8'h03, 8'h44, "R10 pulse on disabled ch3");
    trg[3] = 1'b0;
    expect_cyc(bm(3), 16'h0, 0, 8'h00, 8'h00, "R10 ch3 not armed");
    wr(8'h03, 8'hC4);
    expect_cyc(bm(3), 16'h0, 0, 8'h00, 8'h00, "R10 enable later, nothing armed");

    // R1: last offset of the map
    wr(8'h0F, 8'h8A);
    src[10] = 1'b1;
    expect_cyc(bm(15), bm(15), 1, 8'h0F, 8'h8A, "R1 ch15 routes source 10");
    src = '0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule